// File: doc/BRIEF.md
# Wilkinson Conversion Counter Bank

This block is the digital back end of a bank of single-slope converters, one converter for each analog storage cell. A single fast count clock advances one shared 12-bit counter while the ramp runs. Each cell watches its own comparator bit. On the first rising edge of that bit during a conversion, the cell captures the counter value, and that value becomes the cell's digital result. A separate free-running prescaler divides the count clock by 4096 and drives a slow monitor pin, so the frequency of the count clock can be measured off chip.

A conversion starts when the controller pulses `clr`, which empties the counter and the result store of every cell. The controller then drives `ramp_n` low, and counting takes place only while that pin is low. Once the ramp has run to full scale, every cell reports `done` and a code between 0 and 4095. A cell whose comparator never rose holds 4095. The bank size is set by `N_CELLS`. The count can be carried to the cells in binary or in Gray code, chosen by `GRAY_BUS`. The codes at the ports are always binary.

Top module: `wconv_bank`

## Requirements
- R1: While `clr` is high at a clock edge, that edge sets the counter to 0 and clears every `done` bit and every code to 0. This holds even when `ramp_n` is low at the same edge.
- R2: At each clock edge where `ramp_n` is low and `clr` is low, the counter advances by one. While `ramp_n` is high it holds its value, so a code counts only the edges at which the ramp was active.
- R3: Cell i records a rising edge when its comparator bit was low at one clock edge and is high at the next, with `ramp_n` low at that second edge. At that edge the cell stores the counter value from before the edge, which equals the number of active edges since the clear, and sets `done[i]`. The code of cell i is `code[i*12 +: 12]`, in binary.
- R4: Once `done[i]` is set, further comparator edges leave `code` and `done` of cell i unchanged until the next clear.
- R5: A comparator rising edge that occurs while `ramp_n` is high does not set `done`.
- R6: A comparator bit that is already high when the ramp starts, and stays high, produces no edge. That cell ends the conversion with code 4095.
- R7: The counter stops at 4095 and does not wrap. At every active edge where the counter reads 4095, each cell that is not yet done stores 4095 and sets `done`.
- R8: `mon` is the count clock divided by 4096 and runs regardless of `clr` and `ramp_n`. After reset it is low for 2048 edges, goes high on the 2048th edge, and toggles every 2048 edges from then on.
- R9: A synchronous reset (`rst` high at an edge) clears the counter, every `done` bit, every code and `mon`.
- R10: Cells act independently. The code and flag of one cell do not depend on when any other cell fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Pre-conversion clear of the counter and all results |
| ramp_n | input | 1 | Ramp control; low means the ramp is running and counting is enabled |
| cmp | input | N_CELLS | Comparator outputs, one bit per cell |
| code | output | N_CELLS*12 | Stored binary codes; cell i at bits i*12+11 down to i*12 |
| done | output | N_CELLS | Per-cell result-valid flag |
| mon | output | 1 | Count clock divided by 4096 |

## Verification
A fault in the shared counter shifts the code of every cell that fires later, by the same offset, and that offset is visible one edge after the comparator rises. A counter that wraps or stalls instead of saturating shows up only near full scale, as cells holding values other than 4095. A corrupted per-cell edge detector or sticky flag shows up at the next toggle of that cell's comparator, as a changed code or a dropped `done`. A bad prescaler shows up only at the 2048-edge points of `mon`.

// File: rtl/wconv_pkg.sv
package wconv_pkg;

    localparam int CODE_W = 12;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_FULL = 2'd2
    } cnt_phase_e;

    typedef struct packed {
        logic  done;
        code_t word;
    } cell_state_t;

    function automatic code_t bin2gray(input code_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic code_t gray2bin(input code_t g);
        code_t r;
        r[CODE_W-1] = g[CODE_W-1];
        for (int k = CODE_W - 2; k >= 0; k--) begin
            r[k] = r[k+1] ^ g[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/wconv_counter.sv
module wconv_counter
    import wconv_pkg::*;
#(
    parameter bit GRAY_BUS = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  ramp_act,
    output code_t cnt_bin,
    output code_t cnt_bus,
    output logic  at_max
);

    code_t      cnt_q;
    code_t      cnt_nxt;
    cnt_phase_e phase;

    always_comb begin
        if (!ramp_act)
            phase = CNT_IDLE;
        else if (cnt_q == CODE_MAX)
            phase = CNT_FULL;
        else
            phase = CNT_RUN;
    end

    always_comb begin
        unique case (phase)
            CNT_RUN:  cnt_nxt = cnt_q + code_t'(1);
            default:  cnt_nxt = cnt_q;
        endcase
        if (clr)
            cnt_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    generate
        if (GRAY_BUS) begin : g_gray
            code_t bus_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bus_q <= '0;
                else
                    bus_q <= bin2gray(cnt_nxt);
            end
            assign cnt_bus = bus_q;
        end else begin : g_bin
            assign cnt_bus = cnt_q;
        end
    endgenerate

    assign cnt_bin = cnt_q;
    assign at_max  = (cnt_q == CODE_MAX);

endmodule

// File: rtl/wconv_cell.sv
module wconv_cell
    import wconv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  ramp_act,
    input  logic  at_max,
    input  logic  cmp,
    input  code_t cnt_bus,
    output logic  done,
    output code_t held
);

    cell_state_t st_q;
    cell_state_t st_nxt;
    logic        cmp_q;
    logic        rise;

    assign rise = cmp & ~cmp_q;

    always_comb begin
        st_nxt = st_q;
        if (clr) begin
            st_nxt = '0;
        end else if (ramp_act && !st_q.done && (rise || at_max)) begin
            st_nxt.done = 1'b1;
            st_nxt.word = cnt_bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cmp_q <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            cmp_q <= cmp;
        end
    end

    assign done = st_q.done;
    assign held = st_q.word;

endmodule

// File: rtl/wconv_monitor.sv
module wconv_monitor #(
    parameter int DIV_LOG2 = 12
) (
    input  logic clk,
    input  logic rst,
    output logic mon
);

    logic [DIV_LOG2-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign mon = pre_q[DIV_LOG2-1];

endmodule

// File: rtl/wconv_bank.sv
module wconv_bank
    import wconv_pkg::*;
#(
    parameter int N_CELLS  = 256,
    parameter bit GRAY_BUS = 1'b1,
    parameter int DIV_LOG2 = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        ramp_n,
    input  logic [N_CELLS-1:0]          cmp,
    output logic [N_CELLS*CODE_W-1:0]   code,
    output logic [N_CELLS-1:0]          done,
    output logic                        mon
);

    logic  ramp_act;
    code_t cnt_bin;
    code_t cnt_bus;
    logic  at_max;

    assign ramp_act = ~ramp_n;

    wconv_counter #(.GRAY_BUS(GRAY_BUS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .ramp_act (ramp_act),
        .cnt_bin  (cnt_bin),
        .cnt_bus  (cnt_bus),
        .at_max   (at_max)
    );

    generate
        for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
            code_t held;
            wconv_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .clr      (clr),
                .ramp_act (ramp_act),
                .at_max   (at_max),
                .cmp      (cmp[i]),
                .cnt_bus  (cnt_bus),
                .done     (done[i]),
                .held     (held)
            );
            if (GRAY_BUS) begin : g_dec
                assign code[i*CODE_W +: CODE_W] = gray2bin(held);
            end else begin : g_raw
                assign code[i*CODE_W +: CODE_W] = held;
            end
        end
    endgenerate

    wconv_monitor #(.DIV_LOG2(DIV_LOG2)) u_mon (
        .clk (clk),
        .rst (rst),
        .mon (mon)
    );

endmodule

// File: rtl/wconv_bank_chk.sv
module wconv_bank_chk
    import wconv_pkg::*;
#(
    parameter int N_CELLS = 256
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      clr,
    input logic                      ramp_n,
    input logic [N_CELLS-1:0]        done,
    input logic [N_CELLS*CODE_W-1:0] code,
    input code_t                     cnt
);

    a_r1_clear_flags: assert property (@(posedge clk) disable iff (rst)
        clr |=> (done == '0));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (ramp_n && !clr) |=> $stable(cnt));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!ramp_n && !clr && cnt != CODE_MAX) |=> (cnt == code_t'($past(cnt) + code_t'(1))));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cnt == CODE_MAX && !clr) |=> (cnt == CODE_MAX));

    a_r5_idle_no_latch: assert property (@(posedge clk) disable iff (rst)
        (ramp_n && !clr) |=> $stable(done));

    generate
        for (genvar i = 0; i < N_CELLS; i++) begin : g_cell_chk
            a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
                (done[i] && !clr) |=> (done[i] && $stable(code[i*CODE_W +: CODE_W])));
        end
    endgenerate

endmodule

bind wconv_bank wconv_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .ramp_n (ramp_n),
    .done   (done),
    .code   (code),
    .cnt    (cnt_bin)
);

// File: tb/tb_wconv_bank.sv
module tb_wconv_bank;

    localparam int NC = 8;
    localparam int CW = 12;
    localparam int MAXC = 4095;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              ramp_n = 1'b1;
    logic [NC-1:0]     cmp = '0;
    logic [NC*CW-1:0]  code;
    logic [NC-1:0]     done;
    logic              mon;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    wconv_bank #(.N_CELLS(NC)) dut (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .ramp_n (ramp_n),
        .cmp    (cmp),
        .code   (code),
        .done   (done),
        .mon    (mon)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one clock edge; model of the counter from the requirements
    task automatic tick();
        @(posedge clk);
        if (rst || clr) exp_cnt = 0;
        else if (!ramp_n && exp_cnt < MAXC) exp_cnt++;
        @(negedge clk);
    endtask

    function automatic int cell_code(input int i);
        return int'(code[i*CW +: CW]);
    endfunction

    task automatic start_conv();
        cmp = '0;
        ramp_n = 1'b1;
        clr = 1'b1;
        tick();
        clr = 1'b0;
        ramp_n = 1'b0;
    endtask

    task automatic fire(input int i, output int expv);
        expv = exp_cnt;
        cmp[i] = 1'b1;
        tick();
    endtask

    task automatic t_reset_monitor();
        rst = 1'b1;
        tick(); tick();
        chk("R9 done after reset", int'(done), 0);
        chk("R9 code after reset", int'(code != '0), 0);
        chk("R9 mon after reset", int'(mon), 0);
        rst = 1'b0;
        for (int k = 1; k <= 4096; k++) begin
            tick();
            if (k == 2047) chk("R8 mon before half period", int'(mon), 0);
            if (k == 2048) chk("R8 mon rises at 2048", int'(mon), 1);
            if (k == 4095) chk("R8 mon high at 4095", int'(mon), 1);
            if (k == 4096) chk("R8 mon falls at 4096", int'(mon), 0);
        end
    endtask

    task automatic t_basic();
        int e0, e1, e2;
        start_conv();
        chk("R1 done cleared", int'(done), 0);
        repeat (3) tick();
        fire(0, e0);
        repeat (6) tick();
        fire(6, e1);
        fire(1, e2);
        chk("R3 cell0 code", cell_code(0), e0);
        chk("R3 cell0 value 3", e0, 3);
        chk("R10 cell6 code", cell_code(6), e1);
        chk("R10 cell1 code", cell_code(1), e2);
        chk("R3 done bits", int'(done), 8'b0100_0011);
    endtask

    task automatic t_first_edge();
        int e;
        start_conv();
        repeat (5) tick();
        fire(2, e);
        cmp[2] = 1'b0; tick();
        cmp[2] = 1'b1; tick();
        repeat (4) tick();
        chk("R4 code kept after later edge", cell_code(2), e);
        chk("R4 done kept", int'(done[2]), 1);
    endtask

    task automatic t_pause();
        int e;
        start_conv();
        repeat (10) tick();
        ramp_n = 1'b1;
        repeat (3) tick();
        cmp[4] = 1'b1;
        repeat (5) tick();
        chk("R5 no latch while ramp idle", int'(done[4]), 0);
        ramp_n = 1'b0;
        repeat (5) tick();
        chk("R5 no latch after resume", int'(done[4]), 0);
        fire(5, e);
        chk("R2 code counts active edges only", cell_code(5), 15);
        chk("R2 model agrees", e, 15);
    endtask

    task automatic t_clear_override();
        int e;
        start_conv();
        repeat (4) tick();
        fire(3, e);
        clr = 1'b1;
        tick();
        chk("R1 clear during ramp done", int'(done), 0);
        chk("R1 clear during ramp code", cell_code(3), 0);
        clr = 1'b0;
        cmp = '0;
        repeat (7) tick();
        fire(0, e);
        chk("R1 restart from zero", cell_code(0), 7);
    endtask

    task automatic t_saturate();
        int e;
        cmp = '0;
        ramp_n = 1'b1;
        tick();
        cmp[3] = 1'b1;
        tick();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        ramp_n = 1'b0;
        repeat (4094) tick();
        fire(1, e);
        chk("R7 cell fired at 4094", cell_code(1), 4094);
        chk("R7 only cell1 done before full", int'(done), 8'b0000_0010);
        repeat (10) tick();
        chk("R7 all done at saturation", int'(done), 8'hFF);
        chk("R7 unfired cell holds max", cell_code(0), MAXC);
        chk("R6 precharged comparator gives max", cell_code(3), MAXC);
        chk("R7 no wrap", cell_code(7), MAXC);
        cmp[7] = 1'b1;
        tick();
        chk("R4 edge after saturation ignored", cell_code(7), MAXC);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_monitor();
        t_basic();
        t_first_edge();
        t_pause();
        t_clear_override();
        t_saturate();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule